// File: doc/BRIEF.md
# PLL Lock and Phase-Error Monitor

This block watches a phase-locked loop from the outside. It takes the reference pulse stream and the divided feedback pulse stream as single-cycle strobes, both synchronous to a fast measurement clock. It pairs each reference edge with its feedback edge and counts the measurement-clock cycles between them. From that count it derives three results: a sticky loss-of-lock flag, a flag that says when the lock result can be trusted, and a coarse graded phase-error code.

Software clears both flags with a one-cycle clear pulse. It then waits until the valid flag reads 1 before it trusts the lock flag. The graded code is a thermometer over a set of programmable time windows. It is intended for use while the loop is locked, when the phase error lies within half a reference period. All outputs are registered and can feed a status register directly.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset, `unlock_o`, `lock_valid_o`, `phase_code_o` and `fb_lead_o` are all 0.
- R2: The phase magnitude of a pair is the number of clock cycles from the first edge to its partner edge, and is 0 when both pulses are sampled on the same edge. The outputs change on the edge that samples the partner pulse.
- R3: `fb_lead_o` becomes 1 when the feedback pulse came first in the pair. It becomes 0 when the reference pulse came first or the two pulses coincided.
- R4: On every completed pair, bit i of `phase_code_o` (bit 0 is the narrowest window) is loaded with 1 exactly when the magnitude is greater than threshold i. Threshold i is `win_thr_i[i*CW +: CW]`, and the thresholds are programmed in ascending order.
- R5: A completed pair whose magnitude is greater than `unlock_tol_i` sets `unlock_o`.
- R6: A completed pair whose magnitude is greater than the widest window threshold sets `unlock_o`, even when the magnitude is within `unlock_tol_i`.
- R7: A second reference pulse while a feedback pulse is still awaited, or a second feedback pulse while a reference pulse is still awaited, is a missing edge. It sets `unlock_o`, loads `phase_code_o` with all ones, and leaves `fb_lead_o` unchanged.
- R8: The pulse that revealed a missing edge starts a new measurement, with its partner counted from that pulse.
- R9: Once set, `unlock_o` stays 1 through any later in-tolerance pairs until a clear pulse.
- R10: A clear pulse sets `unlock_o` and `lock_valid_o` to 0 on the edge that samples it, and takes priority over an unlock cause on the same edge.
- R11: After reset or a clear, the first reference pulse only arms the strobe. The second reference pulse sets `lock_valid_o`, which then stays 1 until the next clear.
- R12: The phase counter saturates at 2^CW-1 instead of wrapping, so a very late partner grades as the largest magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | One-cycle strobe per reference edge |
| fb_pulse_i | input | 1 | One-cycle strobe per divided feedback edge |
| clr_pulse_i | input | 1 | Software clear of the unlock and valid flags |
| win_thr_i | input | NWIN*CW | Packed window thresholds, window 0 in the low bits |
| unlock_tol_i | input | CW | Largest magnitude still counted as locked |
| unlock_o | output | 1 | Sticky loss-of-lock flag |
| lock_valid_o | output | 1 | Lock result is meaningful |
| phase_code_o | output | NWIN | Thermometer phase-error code |
| fb_lead_o | output | 1 | Sign of the last pair: feedback came first |

## Verification
The bench builds the block with CW=8 and NWIN=3, with windows at 8, 20 and 40 cycles and a tolerance of 60. Those values put every window crossing, and the case of exceeding the widest window while staying in tolerance, within pairs only tens of cycles long. The 8-bit counter brings saturation within reach at a 300-cycle gap: with wrapping, that gap would read as 44 and leave the lock flag clear. A clear pulse sampled on the same edge as an out-of-tolerance partner exercises the clear-priority rule.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

   // Pairing state of the phase meter
   typedef enum logic [1:0] {
      PM_IDLE     = 2'd0,
      PM_WAIT_FB  = 2'd1,
      PM_WAIT_REF = 2'd2
   } pm_state_t;

endpackage

// File: rtl/phase_meter.sv
module phase_meter
   import lockmon_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ref_i,
   input  logic          fb_i,
   output logic          res_vld_o,
   output logic          res_miss_o,
   output logic          res_lead_o,
   output logic [CW-1:0] res_mag_o
);

   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   pm_state_t     st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic [CW-1:0] cnt_inc;

   assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;

   always_comb begin
      st_d       = st_q;
      cnt_d      = cnt_q;
      res_vld_o  = 1'b0;
      res_miss_o = 1'b0;
      res_lead_o = 1'b0;
      res_mag_o  = '0;
      unique case (st_q)
         PM_IDLE: begin
            if (ref_i && fb_i) begin
               res_vld_o = 1'b1;
            end else if (ref_i) begin
               st_d  = PM_WAIT_FB;
               cnt_d = CNT_ONE;
            end else if (fb_i) begin
               st_d  = PM_WAIT_REF;
               cnt_d = CNT_ONE;
            end
         end
         PM_WAIT_FB: begin
            if (fb_i) begin
               res_vld_o = 1'b1;
               res_mag_o = cnt_q;
               st_d      = ref_i ? PM_WAIT_FB : PM_IDLE;
               cnt_d     = CNT_ONE;
            end else if (ref_i) begin
               res_vld_o  = 1'b1;
               res_miss_o = 1'b1;
               cnt_d      = CNT_ONE;
            end else begin
               cnt_d = cnt_inc;
            end
         end
         PM_WAIT_REF: begin
            if (ref_i) begin
               res_vld_o  = 1'b1;
               res_lead_o = 1'b1;
               res_mag_o  = cnt_q;
               st_d       = fb_i ? PM_WAIT_REF : PM_IDLE;
               cnt_d      = CNT_ONE;
            end else if (fb_i) begin
               res_vld_o  = 1'b1;
               res_miss_o = 1'b1;
               cnt_d      = CNT_ONE;
            end else begin
               cnt_d = cnt_inc;
            end
         end
         default: begin
            st_d  = PM_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= PM_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/err_grader.sv
module err_grader #(
   parameter int CW         = 12,
   parameter int NWIN       = 3,
   parameter bit MISS_FORCE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vld_i,
   input  logic             miss_i,
   input  logic             lead_i,
   input  logic [CW-1:0]    mag_i,
   input  logic [NWIN*CW-1:0] thr_i,
   input  logic [CW-1:0]    tol_i,
   output logic             bad_o,
   output logic [NWIN-1:0]  code_o,
   output logic             lead_o
);

   localparam int TOP = NWIN - 1;

   logic [NWIN-1:0] over_win;
   logic [NWIN-1:0] code_q;
   logic            lead_q;

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      assign over_win[i] = mag_i > thr_i[i*CW +: CW];
   end

   assign bad_o = vld_i && (miss_i || (mag_i > tol_i) || over_win[TOP]);

   if (MISS_FORCE) begin : g_miss_full
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            code_q <= '0;
         else if (vld_i)
            code_q <= miss_i ? {NWIN{1'b1}} : over_win;
      end
   end else begin : g_miss_hold
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            code_q <= '0;
         else if (vld_i && !miss_i)
            code_q <= over_win;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         lead_q <= 1'b0;
      else if (vld_i && !miss_i)
         lead_q <= lead_i;
   end

   assign code_o = code_q;
   assign lead_o = lead_q;

endmodule

// File: rtl/lock_flags.sv
module lock_flags (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic ref_i,
   input  logic bad_i,
   output logic unlock_o,
   output logic valid_o
);

   logic unlock_q, valid_q, armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         unlock_q <= 1'b0;
         valid_q  <= 1'b0;
         armed_q  <= 1'b0;
      end else if (clr_i) begin
         unlock_q <= 1'b0;
         valid_q  <= 1'b0;
         armed_q  <= 1'b0;
      end else begin
         if (bad_i)
            unlock_q <= 1'b1;
         if (ref_i) begin
            armed_q <= 1'b1;
            if (armed_q)
               valid_q <= 1'b1;
         end
      end
   end

   assign unlock_o = unlock_q;
   assign valid_o  = valid_q;

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
   parameter int CW         = 12,
   parameter int NWIN       = 3,
   parameter bit MISS_FORCE = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               ref_pulse_i,
   input  logic               fb_pulse_i,
   input  logic               clr_pulse_i,
   input  logic [NWIN*CW-1:0] win_thr_i,
   input  logic [CW-1:0]      unlock_tol_i,
   output logic               unlock_o,
   output logic               lock_valid_o,
   output logic [NWIN-1:0]    phase_code_o,
   output logic               fb_lead_o
);

   if (CW < 2) begin : g_bad_cw
      $error("pll_lock_monitor: CW must be at least 2");
   end
   if (NWIN < 1) begin : g_bad_nwin
      $error("pll_lock_monitor: NWIN must be at least 1");
   end

   logic          res_vld, res_miss, res_lead, bad;
   logic [CW-1:0] res_mag;

   phase_meter #(.CW(CW)) u_meter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_i      (ref_pulse_i),
      .fb_i       (fb_pulse_i),
      .res_vld_o  (res_vld),
      .res_miss_o (res_miss),
      .res_lead_o (res_lead),
      .res_mag_o  (res_mag)
   );

   err_grader #(.CW(CW), .NWIN(NWIN), .MISS_FORCE(MISS_FORCE)) u_grade (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (res_vld),
      .miss_i (res_miss),
      .lead_i (res_lead),
      .mag_i  (res_mag),
      .thr_i  (win_thr_i),
      .tol_i  (unlock_tol_i),
      .bad_o  (bad),
      .code_o (phase_code_o),
      .lead_o (fb_lead_o)
   );

   lock_flags u_flags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_pulse_i),
      .ref_i    (ref_pulse_i),
      .bad_i    (bad),
      .unlock_o (unlock_o),
      .valid_o  (lock_valid_o)
   );

endmodule

// File: rtl/lock_monitor_chk.sv
module lock_monitor_chk #(
   parameter int CW   = 12,
   parameter int NWIN = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               ref_pulse_i,
   input logic               clr_pulse_i,
   input logic [NWIN*CW-1:0] win_thr_i,
   input logic               unlock_o,
   input logic               lock_valid_o,
   input logic [NWIN-1:0]    phase_code_o
);

   logic thr_asc;
   always_comb begin
      thr_asc = 1'b1;
      for (int i = 1; i < NWIN; i++)
         if (win_thr_i[i*CW +: CW] < win_thr_i[(i-1)*CW +: CW])
            thr_asc = 1'b0;
   end

   // R10
   clr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_pulse_i |=> (!unlock_o && !lock_valid_o));

   // R9
   unlock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(unlock_o) |-> $past(clr_pulse_i));

   // R11
   valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_valid_o) |-> $past(ref_pulse_i));

   // R11
   valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_valid_o && !clr_pulse_i) |=> lock_valid_o);

   // R4
   thermo_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_asc && $past(thr_asc)) |-> ((phase_code_o & (phase_code_o + 1'b1)) == '0));

endmodule

bind pll_lock_monitor lock_monitor_chk #(.CW(CW), .NWIN(NWIN)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ref_pulse_i  (ref_pulse_i),
   .clr_pulse_i  (clr_pulse_i),
   .win_thr_i    (win_thr_i),
   .unlock_o     (unlock_o),
   .lock_valid_o (lock_valid_o),
   .phase_code_o (phase_code_o)
);

// File: tb/sim_pll_lock_monitor.sv
`timescale 1ns/1ps
module sim_pll_lock_monitor;

   localparam int CW   = 8;
   localparam int NWIN = 3;

   typedef struct {
      logic       un;
      logic       en;
      logic [2:0] pe;
      logic       ld;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_p = 1'b0, fb_p = 1'b0, clr_p = 1'b0;
   logic [CW-1:0] thr [NWIN];
   logic [CW-1:0] tol;
   logic [NWIN*CW-1:0] thr_flat;
   logic unlock, valid, lead;
   logic [NWIN-1:0] code;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   exp_t q[$];

   // model state, built from the requirements
   logic m_un = 0, m_en = 0, m_armed = 0, m_ld = 0;
   logic [2:0] m_pe = 0;

   assign thr_flat = {thr[2], thr[1], thr[0]};

   always #4 clk = ~clk;

   pll_lock_monitor #(.CW(CW), .NWIN(NWIN)) u0 (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .ref_pulse_i  (ref_p),
      .fb_pulse_i   (fb_p),
      .clr_pulse_i  (clr_p),
      .win_thr_i    (thr_flat),
      .unlock_tol_i (tol),
      .unlock_o     (unlock),
      .lock_valid_o (valid),
      .phase_code_o (code),
      .fb_lead_o    (lead)
   );

   // monitor: compares queued expectations half a cycle after each edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (unlock !== e.un || valid !== e.en || code !== e.pe || lead !== e.ld) begin
            errors++;
            $display("FAIL %s: got un=%b en=%b pe=%b ld=%b expected un=%b en=%b pe=%b ld=%b",
                     e.tag, unlock, valid, code, lead, e.un, e.en, e.pe, e.ld);
         end
      end
   end

   task automatic push(input string tag);
      exp_t e;
      e.un = m_un; e.en = m_en; e.pe = m_pe; e.ld = m_ld; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drive(input logic r, input logic f, input logic c, input bit res,
                        input int mag, input bit miss, input bit ld, input string tag);
      @(negedge clk);
      ref_p = r; fb_p = f; clr_p = c;
      @(posedge clk);
      #1;
      ref_p = 0; fb_p = 0; clr_p = 0;
      if (res) begin
         for (int i = 0; i < NWIN; i++) m_pe[i] = miss || (mag > int'(thr[i]));
         if (!miss) m_ld = ld;
         if (miss || mag > int'(tol) || mag > int'(thr[NWIN-1])) m_un = 1;
      end
      if (c) begin
         m_un = 0; m_en = 0; m_armed = 0;
      end else if (r) begin
         if (m_armed) m_en = 1; else m_armed = 1;
      end
      push(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic pair(input bit ref_first, input int k, input string tag);
      if (k == 0) begin
         drive(1, 1, 0, 1, 0, 0, 0, tag);
      end else begin
         drive(ref_first, !ref_first, 0, 0, 0, 0, 0, tag);
         idle(k - 1, tag);
         drive(!ref_first, ref_first, 0, 1, (k > 255) ? 255 : k, 0, !ref_first, tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      thr[0] = 8'd8; thr[1] = 8'd20; thr[2] = 8'd40; tol = 8'd60;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      idle(1, "R1");                       // reset state
      drive(0, 0, 1, 0, 0, 0, 0, "R10");
      pair(1, 0, "R2");                    // coincident edges, magnitude 0
      pair(1, 5, "R11");                   // second ref after clear sets valid
      pair(1, 12, "R4");                   // crosses window 0 only
      pair(0, 25, "R3");                   // feedback leads, windows 0 and 1
      pair(0, 45, "R6");                   // above widest window, inside tolerance
      pair(1, 3, "R9");                    // in tolerance, unlock stays set
      drive(0, 0, 1, 0, 0, 0, 0, "R10");
      tol = 8'd10;
      pair(1, 15, "R5");                   // above tolerance only
      tol = 8'd60;
      // missing feedback, then restart from the revealing pulse
      drive(0, 0, 1, 0, 0, 0, 0, "R10");
      drive(1, 0, 0, 0, 0, 0, 0, "R11");
      idle(4, "R7");
      drive(1, 0, 0, 1, 0, 1, 0, "R7");
      idle(2, "R8");
      drive(0, 1, 0, 1, 3, 0, 0, "R8");
      // extra feedback, then restart
      drive(0, 0, 1, 0, 0, 0, 0, "R10");
      drive(0, 1, 0, 0, 0, 0, 0, "R7");
      idle(3, "R7");
      drive(0, 1, 0, 1, 0, 1, 0, "R7");
      idle(1, "R8");
      drive(1, 0, 0, 1, 2, 0, 1, "R8");
      // clear on the same edge as an unlock cause
      drive(0, 0, 1, 0, 0, 0, 0, "R10");
      drive(1, 0, 0, 0, 0, 0, 0, "R10");
      idle(49, "R10");
      drive(0, 1, 1, 1, 50, 0, 0, "R10");
      // saturation: wrapping would read 44 and leave unlock clear
      thr[2] = 8'd254; tol = 8'd255;
      drive(0, 0, 1, 0, 0, 0, 0, "R10");
      pair(1, 300, "R12");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule